// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Lockout

This block receives 8-bit frames from a synchronous serial line. A serial clock and a data line come in from outside, pass through a synchroniser, and on each detected rising edge of the serial clock one data bit is shifted in. The first bit of a frame lands in bit 0 and the eighth in bit 7. There are no start or stop bits.

When a frame completes, it is moved into a holding data register, but only if software has emptied that register. If the register is still full, the frame is dropped and an overrun is flagged. While an overrun is pending, the receiver ignores the line. It also raises a hold output that freezes a paired transmitter. Both stay that way until software clears the overrun flag.

A two-location register port lets software read the data, set the enables and clear the flags. One interrupt-enable bit gates both request outputs: the receive-data-full request and the receive-error request.

Top module: `clkd_rx`

## Requirements
- R1: After reset, the status register (address 1) reads 0x00, the data register (address 0) reads 0x00, and rxiReq, eriReq and txHold are low.
- R2: Bits are assembled least significant first. The first bit sampled in a frame appears in data-register bit 0 and the eighth in bit 7.
- R3: When a frame completes and the full flag (status bit 7) is 0, the frame is written to the data register and the full flag is set. rxiReq is high whenever the full flag is 1 and the interrupt enable (status bit 1) is 1.
- R4: When a frame completes while the full flag is 1, the overrun flag (status bit 6) is set and the data register keeps its previous value.
- R5: eriReq is high whenever the overrun flag is 1 and the interrupt enable is 1. With the interrupt enable at 0, both rxiReq and eriReq stay low, whatever the flags are.
- R6: While the overrun flag is 1, txHold is high and serial clock edges are ignored, so a frame sent then changes neither the data register nor the flags. Writing status bit 6 as 0 clears the flag, and the next frame is then received starting from its first bit.
- R7: A write to the status register with bit 7 at 0 clears the full flag only if the data register has been read since the flag was set. Otherwise the flag stays 1.
- R8: With the receive enable (status bit 0) at 0, serial clock edges are ignored and any partially received frame is discarded. After re-enabling, the next eight bits form a fresh frame.
- R9: Writing 1 to status bit 6 or bit 7 never sets either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, asynchronous to clk |
| serData | input | 1 | Serial data, asynchronous to clk |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regSel | input | 1 | Register select: 0 data, 1 control/status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| rxiReq | output | 1 | Receive-data-full interrupt request |
| eriReq | output | 1 | Receive-error interrupt request |
| txHold | output | 1 | Freezes the paired transmitter while an overrun is pending |

## Verification
The bench builds the block with its defaults: an 8-bit frame and a two-stage synchroniser. This makes every single-bit field position in the data register and every status bit observable with distinct byte patterns. The serial clock is held in each phase for several system cycles, which is longer than the synchroniser and edge-detector latency. A frame's outcome can therefore be sampled at a fixed point after its last bit. This brings within reach overrun stacking on a full register, reception after the lockout is released, the read-then-clear ordering rule, and the discard of a partial frame when reception is disabled.

// File: rtl/clkd_rx_pkg.sv
package clkd_rx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shift;   // take one sampled bit
    logic clear;   // empty the shift register
    logic load;    // move assembled frame into the data register
  } rxStrobe_t;

  // Register select values
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

  // Control/status bit positions
  localparam int EN_BIT   = 0;
  localparam int IE_BIT   = 1;
  localparam int OVR_BIT  = 6;
  localparam int FULL_BIT = 7;
endpackage

// File: rtl/clkd_rx_dp.sv
module clkd_rx_dp
  import clkd_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  rxStrobe_t         strb,
  output logic              bitTick,
  output logic [DATA_W-1:0] rxData
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;
  logic                   clkLast;
  logic [DATA_W-1:0]      shiftReg;
  logic [DATA_W-1:0]      nextShift;

  // Synchronisers for the two asynchronous inputs
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe  <= '0;
          dataPipe <= '0;
        end else begin
          clkPipe  <= serClk;
          dataPipe <= serData;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe  <= '0;
          dataPipe <= '0;
        end else begin
          clkPipe  <= {clkPipe[TOP-1:0], serClk};
          dataPipe <= {dataPipe[TOP-1:0], serData};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkLast <= 1'b0;
    else       clkLast <= clkPipe[TOP];
  end

  assign bitTick   = clkPipe[TOP] & ~clkLast;
  // LSB first: new bit enters at the top, earlier bits move down
  assign nextShift = {dataPipe[TOP], shiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.clear) shiftReg <= '0;
    else if (strb.shift) shiftReg <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxData <= '0;
    else if (strb.load) rxData <= nextShift;
  end

  // R4: the data register changes only on a load strobe
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(rxData));

  // R8: a clear strobe leaves the shift register empty
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> shiftReg == '0);
endmodule

// File: rtl/clkd_rx_ctrl.sv
module clkd_rx_ctrl
  import clkd_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        regWr,
  input  logic        regRd,
  input  logic        regSel,
  input  logic [7:0]  regWdata,
  output rxStrobe_t   strb,
  output logic        fullFlag,
  output logic        ovrFlag,
  output logic        rxEn,
  output logic        intEn
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             rdrRead;
  logic             active;
  logic             frameDone;
  logic             ctrlWr;
  logic             dataRd;
  logic [3:0]       unusedWbits;

  assign unusedWbits = regWdata[5:2];
  assign active    = rxEn & ~ovrFlag;
  assign frameDone = active & bitTick & (bitCnt == LAST_BIT);
  assign ctrlWr    = regWr & (regSel == SEL_CTRL);
  assign dataRd    = regRd & (regSel == SEL_DATA);

  always_comb begin
    strb.shift = active & bitTick;
    strb.clear = ~active;
    strb.load  = frameDone & ~fullFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bitCnt <= '0;
    else if (!active) bitCnt <= '0;
    else if (bitTick) bitCnt <= frameDone ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn  <= 1'b0;
      intEn <= 1'b0;
    end else if (ctrlWr) begin
      rxEn  <= regWdata[EN_BIT];
      intEn <= regWdata[IE_BIT];
    end
  end

  // Full flag: set by a frame transfer, cleared by write-0 after a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         fullFlag <= 1'b0;
    else if (strb.load)                                fullFlag <= 1'b1;
    else if (ctrlWr && !regWdata[FULL_BIT] && rdrRead) fullFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  rdrRead <= 1'b0;
    else if (strb.load)                         rdrRead <= 1'b0;
    else if (dataRd && fullFlag)                rdrRead <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               ovrFlag <= 1'b0;
    else if (frameDone && fullFlag)          ovrFlag <= 1'b1;
    else if (ctrlWr && !regWdata[OVR_BIT])   ovrFlag <= 1'b0;
  end

  // R4
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(fullFlag));

  // R6
  ovr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |-> bitCnt == '0);

  // R7
  full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> $past(ctrlWr && rdrRead));

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> bitCnt == '0);

  // R3
  full_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(bitTick && active));
endmodule

// File: rtl/clkd_rx.sv
module clkd_rx
  import clkd_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regSel,
  input  logic [7:0]        regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              rxiReq,
  output logic              eriReq,
  output logic              txHold
);
  rxStrobe_t         strb;
  logic              bitTick;
  logic [DATA_W-1:0] rxData;
  logic              fullFlag;
  logic              ovrFlag;
  logic              rxEn;
  logic              intEn;
  logic [DATA_W-1:0] statusWord;

  clkd_rx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .strb(strb), .bitTick(bitTick), .rxData(rxData)
  );

  clkd_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .regWr(regWr), .regRd(regRd), .regSel(regSel), .regWdata(regWdata),
    .strb(strb), .fullFlag(fullFlag), .ovrFlag(ovrFlag),
    .rxEn(rxEn), .intEn(intEn)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[EN_BIT]   = rxEn;
    statusWord[IE_BIT]   = intEn;
    statusWord[OVR_BIT]  = ovrFlag;
    statusWord[FULL_BIT] = fullFlag;
  end

  assign regRdata = (regSel == SEL_CTRL) ? statusWord : rxData;
  assign rxiReq   = intEn & fullFlag;
  assign eriReq   = intEn & ovrFlag;
  assign txHold   = ovrFlag;

  // R5
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxiReq || eriReq) |-> intEn);
endmodule

// File: tb/clkd_rx_test.sv
module clkd_rx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       rxiReq, eriReq, txHold;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkd_rx uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .regWr(regWr), .regRd(regRd), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .rxiReq(rxiReq), .eriReq(eriReq), .txHold(txHold)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      serData = b[i];
      idle(3);
      serClk = 1'b1;
      idle(4);
      serClk = 1'b0;
      idle(3);
    end
    idle(6);
  endtask

  task automatic readAndClear();
    logic [7:0] d;
    regRead(1'b0, d);
    regWrite(1'b1, 8'h03);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    regRead(1'b1, d); check("R1 status", d, 8'h00);
    regRead(1'b0, d); check("R1 data", d, 8'h00);
    check("R1 requests", {5'b0, rxiReq, eriReq, txHold}, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    regWrite(1'b1, 8'h03);
    sendBits(8'hA5, 8);
    regRead(1'b0, d); check("R2 lsb-first A5", d, 8'hA5);
    regRead(1'b1, d); check("R3 full set", d, 8'h83);
    check("R3 rxiReq", {7'b0, rxiReq}, 8'h01);
    regWrite(1'b1, 8'h03);
    regRead(1'b1, d); check("R7 clear after read", d, 8'h03);
    check("R7 rxiReq drops", {7'b0, rxiReq}, 8'h00);
    sendBits(8'h01, 8);
    regRead(1'b0, d); check("R2 first bit is bit0", d, 8'h01);
    readAndClear();
  endtask

  task automatic t_noReadClear();
    logic [7:0] d;
    sendBits(8'h3C, 8);
    regWrite(1'b1, 8'h03);
    regRead(1'b1, d); check("R7 no clear without read", d, 8'h83);
    readAndClear();
    regRead(1'b1, d); check("R7 cleared after read", d, 8'h03);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    sendBits(8'h11, 8);
    sendBits(8'h22, 8);
    regRead(1'b1, d); check("R4 overrun set", d, 8'hC3);
    regRead(1'b0, d); check("R4 data kept", d, 8'h11);
    check("R5 eriReq", {7'b0, eriReq}, 8'h01);
    check("R6 txHold", {7'b0, txHold}, 8'h01);
    regRead(1'b0, d);
    regWrite(1'b1, 8'hC3);
    sendBits(8'h33, 8);
    regRead(1'b0, d); check("R6 frame ignored", d, 8'h11);
    regRead(1'b1, d); check("R6 flags unchanged", d, 8'hC3);
    regWrite(1'b1, 8'h03);
    regRead(1'b1, d); check("R6 both cleared", d, 8'h03);
    check("R6 released", {6'b0, eriReq, txHold}, 8'h00);
    sendBits(8'h44, 8);
    regRead(1'b0, d); check("R6 restart", d, 8'h44);
    readAndClear();
  endtask

  task automatic t_gate();
    logic [7:0] d;
    regWrite(1'b1, 8'h01);
    sendBits(8'h55, 8);
    sendBits(8'h66, 8);
    regRead(1'b1, d); check("R5 flags with ie off", d, 8'hC1);
    check("R5 requests gated", {6'b0, rxiReq, eriReq}, 8'h00);
    regWrite(1'b1, 8'hC3);
    check("R5 requests with ie on", {6'b0, rxiReq, eriReq}, 8'h03);
    regRead(1'b0, d);
    regWrite(1'b1, 8'h03);
    regWrite(1'b1, 8'hC3);
    regRead(1'b1, d); check("R9 write 1 no set", d, 8'h03);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    sendBits(8'hFF, 3);
    regWrite(1'b1, 8'h02);
    sendBits(8'hFF, 8);
    regRead(1'b1, d); check("R8 disabled ignores", d, 8'h02);
    regWrite(1'b1, 8'h03);
    sendBits(8'h96, 8);
    regRead(1'b0, d); check("R8 fresh frame", d, 8'h96);
    readAndClear();
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_noReadClear();
    t_overrun();
    t_gate();
    t_disable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule